// File: doc/BRIEF.md
# Pixel Pack and Merge Unit

This unit is the formatting stage of a SIMD media datapath. One operation is issued per cycle, with two 64-bit operands, a 9-bit operation code and a 5-bit scale value taken from the graphics status register. The unit turns wide fixed-point lanes into saturated bytes or halfwords, widens bytes into halfword lanes, or interleaves the bytes of two 32-bit words. Every valid operation produces a result one cycle later, together with a flag that says whether the result is 64 bits wide or only 32 bits wide.

The pack operations scale each source lane by a left shift and then shift it arithmetically right by a fixed amount, before they saturate it. The intermediate values are 64 bits wide, so that no left shift can overflow before the right shift. The 32-bit pack keeps most of operand A, moved up by one byte, and writes the packed bytes into the low byte of each 32-bit word. An operation code that the unit does not know produces a zero result and raises an illegal flag.

Top module: `pixel_pack_merge`

## Requirements
- R1: While rst_n is low, and after it rises until the first valid operation, res_valid, res_wide, res_illegal and res_data are all zero.
- R2: An operation presented with op_valid high at a rising edge appears on the outputs after that edge, with res_valid high. A cycle with op_valid low drives res_valid low on the following cycle and leaves res_data, res_wide and res_illegal unchanged.
- R3: Code 0x03B (halfword-to-byte pack) uses only scale_in[3:0], and scale_in[4] has no effect. Each signed halfword n of src_b is shifted left by the scale and then arithmetically right by 7. The value is clamped to 0..255 and placed in bits [8n+7:8n]. Bits [63:32] are zero and res_wide is 0.
- R4: Code 0x03A (word-to-byte pack with carry-in) uses all 5 scale bits. Bits [15:8], [23:16], [31:24], [47:40], [55:48] and [63:56] of the result are bytes 0, 1, 2, 4, 5 and 6 of src_a. Bits [32w+7:32w] hold signed word w of src_b, shifted left by the scale, arithmetically right by 23 and clamped to 0..255. res_wide is 1.
- R5: Code 0x03D (word-to-halfword pack) shifts each signed word w of src_b left by the 5-bit scale and then arithmetically right by 16. The value saturates to -32768..32767 and is placed in bits [16w+15:16w]. Bits [63:32] are zero and res_wide is 0.
- R6: Code 0x04D (expand) takes byte n of src_b[31:0] and places it, shifted left by 4 and zero-extended, in bits [16n+15:16n]. res_wide is 1, and src_a and src_b[63:32] have no effect.
- R7: Code 0x04B (merge) builds the result bytes from the least significant byte upward, in this order: src_b byte 0, src_a byte 0, src_b byte 1, src_a byte 1, up to src_a byte 3 in bits [63:56]. res_wide is 1.
- R8: Any other code gives res_data equal to zero, res_wide equal to 0 and res_illegal equal to 1. Every supported code gives res_illegal equal to 0.
- R9: The scaled intermediate does not wrap. For a word of 0x7FFFFFFF with a scale of 31, the word-to-byte pack gives 255, and for a word of 0x40000000 with a scale of 2, the word-to-halfword pack gives 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 9 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| scale_in | input | 5 | Scale field from the status register |
| res_valid | output | 1 | A result is present |
| res_data | output | 64 | Result; only bits [31:0] are meaningful when res_wide is 0 |
| res_wide | output | 1 | The result is 64 bits wide |
| res_illegal | output | 1 | The operation code was not recognised |

## Verification
The assertions take for granted that op_code, src_a, src_b and scale_in are stable and known at every edge where op_valid is high. Some of them compare the outputs against earlier operand bytes through $past, so they also assume that reset has been released for at least one cycle before the first operation. The bench changes inputs only on falling edges and raises op_valid for exactly one cycle per operation. It always holds reset for several cycles before the first operation. It deliberately changes the operands while op_valid is low, to show that nothing is captured in those cycles.

// File: rtl/pixel_pack_merge.sv
module pixel_pack_merge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [8:0]  op_code,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [4:0]  scale_in,
  output logic        res_valid,
  output logic [63:0] res_data,
  output logic        res_wide,
  output logic        res_illegal
);

  localparam logic [8:0] OP_PACK16  = 9'h03b;
  localparam logic [8:0] OP_PACK32  = 9'h03a;
  localparam logic [8:0] OP_PACKFIX = 9'h03d;
  localparam logic [8:0] OP_EXPAND  = 9'h04d;
  localparam logic [8:0] OP_MERGE   = 9'h04b;

  function automatic logic [7:0] sat_u8(input logic signed [63:0] v);
    if (v < 0)                 return 8'h00;
    else if (v > 64'sd255)     return 8'hff;
    else                       return v[7:0];
  endfunction

  function automatic logic [15:0] sat_s16(input logic signed [63:0] v);
    if (v < -64'sd32768)       return 16'h8000;
    else if (v > 64'sd32767)   return 16'h7fff;
    else                       return v[15:0];
  endfunction

  logic [3:0]  sc_narrow;
  logic [7:0]  p16_b [4];
  logic [15:0] exp_h [4];
  logic [15:0] mrg_h [4];
  logic [7:0]  p32_b [2];
  logic [15:0] fix_h [2];
  logic        unused_top_byte;

  assign sc_narrow       = scale_in[3:0];
  assign unused_top_byte = ^src_a[63:56];

  for (genvar i = 0; i < 4; i++) begin : g_half
    logic signed [63:0] ext;
    logic signed [63:0] shl;
    assign ext      = {{48{src_b[16*i+15]}}, src_b[16*i +: 16]};
    assign shl      = ext <<< sc_narrow;
    assign p16_b[i] = sat_u8(shl >>> 7);
    assign exp_h[i] = {4'h0, src_b[8*i +: 8], 4'h0};
    assign mrg_h[i] = {src_a[8*i +: 8], src_b[8*i +: 8]};
  end

  for (genvar w = 0; w < 2; w++) begin : g_word
    logic signed [63:0] ext;
    logic signed [63:0] shl;
    assign ext      = {{32{src_b[32*w+31]}}, src_b[32*w +: 32]};
    assign shl      = ext <<< scale_in;
    assign p32_b[w] = sat_u8(shl >>> 23);
    assign fix_h[w] = sat_s16(shl >>> 16);
  end

  logic [63:0] nxt_data;
  logic        nxt_wide;
  logic        nxt_ill;

  always_comb begin
    nxt_data = '0;
    nxt_wide = 1'b0;
    nxt_ill  = 1'b0;
    case (op_code)
      OP_PACK16:  nxt_data = {32'h0, p16_b[3], p16_b[2], p16_b[1], p16_b[0]};
      OP_PACK32: begin
        nxt_data = {src_a[55:32], p32_b[1], src_a[23:0], p32_b[0]};
        nxt_wide = 1'b1;
      end
      OP_PACKFIX: nxt_data = {32'h0, fix_h[1], fix_h[0]};
      OP_EXPAND: begin
        nxt_data = {exp_h[3], exp_h[2], exp_h[1], exp_h[0]};
        nxt_wide = 1'b1;
      end
      OP_MERGE: begin
        nxt_data = {mrg_h[3], mrg_h[2], mrg_h[1], mrg_h[0]};
        nxt_wide = 1'b1;
      end
      default:    nxt_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_wide    <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data    <= nxt_data;
        res_wide    <= nxt_wide;
        res_illegal <= nxt_ill;
      end
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid && $stable(res_data) && $stable(res_wide) && $stable(res_illegal));

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (res_data == 64'h0) && !res_wide);

  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_wide) |-> (res_data[63:32] == 32'h0));

  assert_carry_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_PACK32) |=>
      res_wide && (res_data[63:40] == $past(src_a[55:32])) && (res_data[31:8] == $past(src_a[23:0])));

  assert_expand_nibbles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_EXPAND) |=>
      res_wide && !res_illegal && ((res_data & 64'hf00f_f00f_f00f_f00f) == 64'h0));

  assert_merge_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MERGE) |=>
      (res_data[7:0] == $past(src_b[7:0])) && (res_data[63:56] == $past(src_a[31:24])));

endmodule

// File: tb/pixel_pack_merge_tb_top.sv
module pixel_pack_merge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [8:0]  op_code = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [4:0]  scale_in = '0;
  logic        res_valid;
  logic [63:0] res_data;
  logic        res_wide;
  logic        res_illegal;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pixel_pack_merge dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .scale_in(scale_in),
    .res_valid(res_valid), .res_data(res_data), .res_wide(res_wide),
    .res_illegal(res_illegal)
  );

  // {req[4], op[9], a[64], b[64], scale[5], expected[64], wide, illegal}
  localparam int NV = 10;
  localparam logic [211:0] VECS [NV] = '{
    {4'd3, 9'h03b, 64'h0, 64'h0000_0100_ff80_0080, 5'd0,  64'h0000_0000_0002_0001, 1'b0, 1'b0}, // R3
    {4'd3, 9'h03b, 64'h0, 64'h0000_0100_ff80_0080, 5'h14, 64'h0000_0000_0020_0010, 1'b0, 1'b0}, // R3 top scale bit ignored
    {4'd3, 9'h03b, 64'h0, 64'h7fff_8000_4000_0200, 5'h11, 64'h0000_0000_ff00_ff08, 1'b0, 1'b0}, // R3 clamp
    {4'd4, 9'h03a, 64'h1122_3344_5566_7788, 64'h0000_0100_ffff_ffff, 5'd16, 64'h2233_4402_6677_8800, 1'b1, 1'b0}, // R4
    {4'd9, 9'h03a, 64'h0, 64'h8000_0000_7fff_ffff, 5'd31, 64'h0000_0000_0000_00ff, 1'b1, 1'b0}, // R9
    {4'd5, 9'h03d, 64'h0, 64'hffff_0000_0001_0000, 5'd0,  64'h0000_0000_ffff_0001, 1'b0, 1'b0}, // R5
    {4'd9, 9'h03d, 64'h0, 64'hc000_0000_4000_0000, 5'd2,  64'h0000_0000_8000_7fff, 1'b0, 1'b0}, // R9 saturate
    {4'd6, 9'h04d, 64'h5555_5555_5555_5555, 64'hdead_beef_ff80_0102, 5'd7, 64'h0ff0_0800_0010_0020, 1'b1, 1'b0}, // R6
    {4'd7, 9'h04b, 64'h1234_5678_a3a2_a1a0, 64'hcafe_f00d_b3b2_b1b0, 5'd0, 64'ha3b3_a2b2_a1b1_a0b0, 1'b1, 1'b0}, // R7
    {4'd8, 9'h03c, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 5'd3, 64'h0, 1'b0, 1'b1} // R8
  };

  task automatic check(input string tag, input logic [66:0] got, input logic [66:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b, input logic [4:0] sc);
    @(negedge clk);
    op_code = op; src_a = a; src_b = b; scale_in = sc; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {res_valid, res_wide, res_illegal, res_data}, 67'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {res_valid, res_wide, res_illegal, res_data}, 67'h0);

    for (int k = 0; k < NV; k++) begin
      logic [211:0] v;
      v = VECS[k];
      issue(v[207:199], v[198:135], v[134:71], v[70:66]);
      check($sformatf("R%0d vector %0d", v[211:208], k),
            {res_valid, res_wide, res_illegal, res_data},
            {1'b1, v[1], v[0], v[65:2]});
    end

    // R2: idle cycle with changed operands holds the last result
    issue(9'h04b, 64'h0, 64'h0000_0000_0403_0201, 5'd0);
    @(negedge clk);
    op_code = 9'h03b; src_a = '1; src_b = '1;
    @(negedge clk);
    check("R2 hold", {res_valid, res_wide, res_illegal, res_data},
          {1'b0, 1'b1, 1'b0, 64'h0004_0003_0002_0001});

    // R8: legal code after an illegal one clears the flag
    issue(9'h1ff, 64'h0, 64'h0, 5'd0);
    check("R8 all-ones code", {res_valid, res_wide, res_illegal, res_data}, {3'b101, 64'h0});
    issue(9'h03d, 64'h0, 64'h0000_0000_0002_0000, 5'd0);
    check("R8 flag clears on R5 op", {res_valid, res_wide, res_illegal, res_data},
          {3'b100, 64'h0000_0000_0000_0002});

    // R6: operand A ignored by expand
    issue(9'h04d, 64'h0, 64'h0000_0000_0000_00ff, 5'd0);
    check("R6 zero A", {res_valid, res_wide, res_illegal, res_data}, {3'b110, 64'h0ff0});
    issue(9'h04d, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_00ff, 5'd0);
    check("R6 ones A", {res_valid, res_wide, res_illegal, res_data}, {3'b110, 64'h0ff0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule